// File: doc/BRIEF.md
# Bit-Serial Polynomial Remainder Engine

This block divides a serial bit stream by a fixed binary polynomial and keeps the running remainder in a shift register. The register has one stage per bit of the check field. The top stage feeds back through XOR gates into every lower stage whose divisor coefficient is set. The divisor is a parameter, so one design covers short teaching polynomials and the common 12-, 16- and 32-bit check codes.

The same hardware serves both ends of a link. A sender clears the engine and shifts in the message, most significant bit first. It then shifts in as many zero bits as the check field is wide, and reads the remainder as the check field to append. A receiver clears the engine and shifts in the whole received frame, message plus check field. A zero remainder means no error was detected. Bits are taken only on cycles with the valid strobe high, so the source may pause at any time.

Top module: `crc_serial_engine`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every register stage is 0 and `rem_zero` is 1.
- R2: When `clr` is high at a clock edge, the register becomes all zeros on that edge, whatever `bit_vld` and `bit_in` are.
- R3: When neither `clr` nor `bit_vld` is high at a clock edge, `rem_out` keeps its value, whatever `bit_in` does.
- R4: On a valid bit with the top stage at 0, the register shifts up one place and `bit_in` enters stage 0.
- R5: On a valid bit with the top stage at 1, the shifted value is XORed with the divisor's lower coefficients. Stage 0 is always included in the XOR, so the result of stage 0 is the inverse of `bit_in`.
- R6: Generate mode: after a clear, the message MSB first followed by WIDTH zero bits leaves the check field in the register. For the divisor 110101 and message 1010001101 the result is 01110.
- R7: Check mode: after a clear, shifting in a frame made of a message and its own check field leaves the register all zeros, with `rem_zero` high.
- R8: A frame with one bit flipped leaves a non-zero remainder. For the divisor 11001, message 00111011001 gives check field 0100, and codeword 001100110010100 (one bit flipped) gives a non-zero result.
- R9: `rem_out[WIDTH-1]` is the top stage, which is the most significant bit of the check field and the first check bit to transmit. `rem_zero` is high exactly when all of `rem_out` is 0, in the same cycle.
- R10: The divisor parameter holds the coefficients below the leading term. Widths of 12, 16 and 32 with the standard 12-bit, 16-bit, 16-bit CCITT and 32-bit divisors give the mathematically correct remainder. The 16-bit CCITT divisor (lower coefficients 0x1021) applied to the ASCII digits 1 to 9, plus 16 zero bits, gives 0x31C3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero the register before a new message; wins over `bit_vld` |
| bit_vld | input | 1 | `bit_in` is taken at this edge |
| bit_in | input | 1 | Serial data, most significant bit first |
| rem_out | output | WIDTH | Register contents; bit WIDTH-1 is the check-field MSB |
| rem_zero | output | 1 | High when the register is all zeros |

## Verification
On every cycle the assertions check clearing and its priority, holding when no bit is valid, the plain shift when the top stage is clear, and the inverted entry into stage 0 when feedback is active. Whether a whole frame yields the right check field, whether a good codeword clears to zero, and whether a corrupted one does not, can only be shown by the bench's scenarios. These cover the worked examples, a known 16-bit check value and random messages with random pauses. The bench runs them on four divisor widths at once and compares each result with a polynomial long division it computes itself.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;
  // Divisor coefficients below the leading term, for common check codes.
  localparam logic [4:0]  DIV5_DEMO  = 5'b10101;       // x^5+x^4+x^2+1
  localparam logic [3:0]  DIV4_DEMO  = 4'b1001;        // x^4+x^3+1
  localparam logic [11:0] DIV12_STD  = 12'h80F;
  localparam logic [15:0] DIV16_STD  = 16'h8005;
  localparam logic [15:0] DIV16_CCIT = 16'h1021;
  localparam logic [31:0] DIV32_STD  = 32'h04C1_1DB7;
endpackage

// File: rtl/crc_tap_net.sv
module crc_tap_net #(
  parameter int unsigned WIDTH = 5,
  parameter logic [WIDTH-1:0] DIVISOR = 5'b10101
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             din,
  output logic [WIDTH-1:0] nxt
);
  // Stage 0 always receives feedback: the divisor's constant term is 1.
  localparam logic [WIDTH-1:0] TAPS = {DIVISOR[WIDTH-1:1], 1'b1};

  logic fb;
  assign fb = cur[WIDTH-1];

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_low
        assign nxt[0] = din ^ fb;
      end else if (TAPS[i]) begin : g_xor
        assign nxt[i] = cur[i-1] ^ fb;
      end else begin : g_wire
        assign nxt[i] = cur[i-1];
      end
    end
  endgenerate
endmodule

// File: rtl/crc_zero_detect.sv
module crc_zero_detect #(
  parameter int unsigned WIDTH = 5
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);
  assign is_zero = ~|value;
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_serial_pkg::*;
#(
  parameter int unsigned WIDTH = 5,
  parameter logic [WIDTH-1:0] DIVISOR = DIV5_DEMO
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [WIDTH-1:0] rem_out,
  output logic             rem_zero
);
  logic [WIDTH-1:0] rem_q;
  logic [WIDTH-1:0] rem_d;

  crc_tap_net #(.WIDTH(WIDTH), .DIVISOR(DIVISOR)) u_taps (
    .cur (rem_q),
    .din (bit_in),
    .nxt (rem_d)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem_q <= '0;
    end else if (bit_vld) begin
      rem_q <= rem_d;
    end
  end

  assign rem_out = rem_q;

  crc_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value   (rem_q),
    .is_zero (rem_zero)
  );

  // R1: reset empties the register
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (rem_out == '0));

  // R2: clear wins over a valid bit, and the flag follows
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr && bit_vld) |=> (rem_out == '0));
  a_r2_clear_flag: assert property (@(posedge clk) disable iff (rst)
    clr |=> rem_zero);

  // R3: idle cycles hold the remainder
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !bit_vld) |=> $stable(rem_out));

  // R4: no feedback means a plain shift
  a_r4_plain_shift: assert property (@(posedge clk) disable iff (rst)
    (!clr && bit_vld && !rem_out[WIDTH-1])
      |=> (rem_out == {$past(rem_out[WIDTH-2:0]), $past(bit_in)}));

  // R5: with feedback, stage 0 takes the inverted input bit
  a_r5_low_tap: assert property (@(posedge clk) disable iff (rst)
    (!clr && bit_vld && rem_out[WIDTH-1]) |=> (rem_out[0] == !$past(bit_in)));
endmodule

// File: tb/crc_serial_engine_tb.sv
module crc_serial_engine_tb;
  import crc_serial_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;

  logic [4:0]  r5;  logic z5;
  logic [3:0]  r4;  logic z4;
  logic [15:0] r16; logic z16;
  logic [31:0] r32; logic z32;

  always #2.5 clk = ~clk;

  crc_serial_engine #(.WIDTH(5), .DIVISOR(DIV5_DEMO)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
    .rem_out(r5), .rem_zero(z5));
  crc_serial_engine #(.WIDTH(4), .DIVISOR(DIV4_DEMO)) u_dut_w4 (
    .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
    .rem_out(r4), .rem_zero(z4));
  crc_serial_engine #(.WIDTH(16), .DIVISOR(DIV16_CCIT)) u_dut_w16 (
    .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
    .rem_out(r16), .rem_zero(z16));
  crc_serial_engine #(.WIDTH(32), .DIVISOR(DIV32_STD)) u_dut_w32 (
    .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
    .rem_out(r32), .rem_zero(z32));

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [127:0] stream = '0;   // stream[0] = most recent bit
  int slen = 0;

  // Polynomial long division of the recorded stream by x^w + low.
  function automatic logic [31:0] ref_rem(logic [127:0] s, int len, int w,
                                          logic [31:0] low);
    logic [32:0] p;
    logic [63:0] mask;
    p = (33'd1 << w) | {1'b0, low};
    for (int i = len - 1; i >= w; i--) begin
      if (s[i]) begin
        for (int j = 0; j <= w; j++) s[i-w+j] = s[i-w+j] ^ p[j];
      end
    end
    mask = (64'd1 << w) - 64'd1;
    return s[31:0] & mask[31:0];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [31:0] e;
    e = ref_rem(stream, slen, 5, 32'(DIV5_DEMO));
    check(32'(r5) == e && z5 == (e == 0), {req, " w5"}, 32'(r5), e);
    e = ref_rem(stream, slen, 4, 32'(DIV4_DEMO));
    check(32'(r4) == e && z4 == (e == 0), {req, " w4"}, 32'(r4), e);
    e = ref_rem(stream, slen, 16, 32'(DIV16_CCIT));
    check(32'(r16) == e && z16 == (e == 0), {req, " w16"}, 32'(r16), e);
    e = ref_rem(stream, slen, 32, DIV32_STD);
    check(r32 == e && z32 == (e == 0), {req, " w32"}, r32, e);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk); clr = 1'b0; bit_vld = 1'b0;
    stream = '0; slen = 0;
  endtask

  task automatic shift_vec(logic [127:0] v, int len, bit gaps);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk);
      if (gaps && ($urandom % 4 == 0)) begin
        bit_vld = 1'b0; bit_in = 1'($urandom);
        @(negedge clk);
      end
      bit_vld = 1'b1; bit_in = v[i];
      stream = {stream[126:0], v[i]}; slen++;
    end
    @(negedge clk); bit_vld = 1'b0;
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(r5 == 0 && z5 && r4 == 0 && z4 && r16 == 0 && z16 && r32 == 0 && z32,
          "R1 reset", 32'(r5), 0);

    // R6 / R9: generate mode worked example, MSB of field in top stage
    do_clear();
    shift_vec(128'b101000110100000, 15, 1'b0);
    check(r5 == 5'b01110, "R6 fcs", 32'(r5), 32'b01110);
    check(r5[4] == 1'b0 && r5[3] == 1'b1 && !z5, "R9 bit order", 32'(r5), 32'b01110);
    check_all("R6");

    // R7: check mode on the transmitted frame
    do_clear();
    shift_vec(128'b101000110101110, 15, 1'b0);
    check(r5 == 0 && z5, "R7 good frame", 32'(r5), 0);

    // R8: second worked example, good codeword, corrupted codeword
    do_clear();
    shift_vec(128'b001110110010000, 15, 1'b0);
    check(r4 == 4'b0100, "R8 fcs", 32'(r4), 32'b0100);
    do_clear();
    shift_vec(128'b001110110010100, 15, 1'b0);
    check(r4 == 0 && z4, "R8 codeword", 32'(r4), 0);
    do_clear();
    shift_vec(128'b001100110010100, 15, 1'b0);
    check(r4 != 0 && !z4, "R8 flipped bit", 32'(r4), 32'hFFFFFFFF);

    // R10: known 16-bit CCITT value on "123456789"
    do_clear();
    shift_vec({56'd0, 72'h313233343536373839}, 72, 1'b1);
    shift_vec(128'd0, 16, 1'b0);
    check(r16 == 16'h31C3, "R10 ccitt digits", 32'(r16), 32'h31C3);

    // R3: idle cycles with a wiggling input change nothing
    begin
      logic [31:0] held;
      do_clear();
      shift_vec(128'h0123_4567_89AB, 48, 1'b0);
      held = r32;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); bit_vld = 1'b0; bit_in = 1'($urandom);
      end
      @(negedge clk);
      check(r32 == held, "R3 idle hold", r32, held);
      check_all("R3");
    end

    // R2: clear with a valid bit present empties every width
    do_clear();
    check(r5 == 0 && r4 == 0 && r16 == 0 && r32 == 0 && z32, "R2 clear priority",
          r32, 0);

    // R4 / R5 / R10: random messages with pauses, all widths
    for (int t = 0; t < 24; t++) begin
      logic [127:0] v;
      int len;
      v = {$urandom, $urandom, $urandom, $urandom};
      len = 1 + int'($urandom % 96);
      do_clear();
      shift_vec(v, len, 1'b1);
      check_all("R4 R5 R10 random");
    end

    // R7 / R10: append the 32-bit field to a random message, then check
    begin
      logic [127:0] m;
      logic [31:0] f;
      m = {64'd0, $urandom, $urandom};
      f = ref_rem({m[95:0], 32'd0}, 96, 32, DIV32_STD);
      do_clear();
      shift_vec({m[95:0], f}, 96, 1'b1);
      check(r32 == 0 && z32, "R7 R10 w32 frame", r32, 0);
    end

    // R1: reset again mid-stream
    shift_vec(128'hF0F0, 16, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(r5 == 0 && r16 == 0 && r32 == 0 && z5, "R1 reset later", 32'(r16), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule